// File: doc/BRIEF.md
# Supply-Loss Write Guard for a Byte-Wide Static Memory

This block is a synchronous controller placed between a host's SRAM-style strobes (active-low chip select, write strobe and output strobe) and a 32768-byte memory array. On every clock it reads an unsigned millivolt code from a supply monitor. From that code it keeps one of four power states: a sealed shipping state in which the backup cell is never connected, normal operation, write-protected, and battery backup.

Host reads and writes reach the array only in the normal state. A write is committed to the array as a single-cycle strobe after the host closes its write window, so a window that is cut short by a supply drop writes nothing. The block drives the read-data enable for the host pins, a backup-source select, and a flag that reports whether retention can be relied on. Thresholds for resume, protect, backup switching and unsealing are parameters. There is hysteresis between the protect level and the resume level.

Top module: `pfs_supervisor`

## Requirements
- R1: After reset the state code is 00 (sealed), the backup select is 0, the retention flag is 0, and no read enable or write strobe is active.
- R2: The state stays sealed, with the backup select at 0, while the supply code is at or below SEAL_MV (default 4250), even below SWITCH_MV. The first sample above SEAL_MV leaves the sealed state, and the state never returns to sealed until the next reset.
- R3: Leaving sealed, protected or backup to normal (code 01) requires a sample above RESUME_MV (default 4750). A sealed or backup block whose sample lies above its exit level but at or below RESUME_MV enters protected (code 10).
- R4: In normal, a sample at or below PROTECT_MV (default 4500) moves the state to protected at the next edge. Samples between PROTECT_MV and RESUME_MV keep it normal.
- R5: A sample below SWITCH_MV (default 3000) moves normal or protected to backup (code 11). In backup, a sample above SWITCH_MV leaves backup.
- R6: The backup select is 1 exactly while the state is backup. The retention flag is 1 in every state except sealed.
- R7: In normal with write strobe high and chip select and output strobe low, the array read enable and the host read-data enable are 1 in the same cycle. The host address reaches the array, and the array byte reaches the host data output.
- R8: A low write strobe turns the host read-data enable off in the same cycle, even while chip select and output strobe are low.
- R9: A write window is open while chip select and write strobe are both low. In the clock after the first edge at which the window is seen closed, the block raises a one-cycle array write strobe. That strobe carries the address and data sampled at the last edge of the open window.
- R10: If the state leaves normal while a window is open, that window is dropped and no write strobe follows when it closes.
- R11: Outside normal, the strobe, address and data inputs have no effect: the read enables and the write strobe stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_mv | input | 13 | Supply level, unsigned millivolts |
| host_ce_n | input | 1 | Host chip select, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_oe_n | input | 1 | Host output strobe, active low |
| host_addr | input | 15 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data toward host pins (0 when disabled) |
| host_rdata_oe | output | 1 | Drive enable for host data pins; 0 means high impedance |
| arr_addr | output | 15 | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_wr_en | output | 1 | One-cycle array write strobe |
| arr_rd_en | output | 1 | Array read enable |
| arr_rdata | input | 8 | Array read data |
| bkup_sel | output | 1 | Connect backup source to the array |
| retain_ok | output | 1 | Retention is valid (not sealed) |
| pwr_state | output | 2 | State code: 00 sealed, 01 normal, 10 protected, 11 backup |

## Verification
The supply code is swept through sequences that separate each threshold from its neighbours. A low start that stays sealed separates the seal gate from the backup switch. Values between the protect and resume levels, approached from both sides, show the hysteresis. A dip below the switch level followed by a partial recovery shows that backup exits to protected and not to normal. The host strobes are tried as a plain read, a completed write, a write strobe asserted during a read, strobes applied while protected, and a write window interrupted by a supply drop. These separate a committed write from an aborted one and separate gated outputs from passed ones.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    localparam int VCC_W  = 13;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PS_SEALED  = 2'b00,
        PS_NORMAL  = 2'b01,
        PS_PROTECT = 2'b10,
        PS_BACKUP  = 2'b11
    } pwr_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    function automatic pwr_state_t next_pwr(
        input pwr_state_t       cur,
        input logic [VCC_W-1:0] v,
        input logic [VCC_W-1:0] resume_mv,
        input logic [VCC_W-1:0] protect_mv,
        input logic [VCC_W-1:0] switch_mv,
        input logic [VCC_W-1:0] seal_mv
    );
        pwr_state_t n;
        n = cur;
        unique case (cur)
            PS_SEALED:  if (v > seal_mv) n = (v > resume_mv) ? PS_NORMAL : PS_PROTECT;
            PS_NORMAL:  if (v < switch_mv) n = PS_BACKUP;
                        else if (v <= protect_mv) n = PS_PROTECT;
            PS_PROTECT: if (v < switch_mv) n = PS_BACKUP;
                        else if (v > resume_mv) n = PS_NORMAL;
            PS_BACKUP:  if (v > resume_mv) n = PS_NORMAL;
                        else if (v > switch_mv) n = PS_PROTECT;
            default:    n = PS_SEALED;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/pfs_power_fsm.sv
module pfs_power_fsm
    import pfs_pkg::*;
#(
    parameter int RESUME_MV  = 4750,
    parameter int PROTECT_MV = 4500,
    parameter int SWITCH_MV  = 3000,
    parameter int SEAL_MV    = 4250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VCC_W-1:0] vcc_mv,
    output pwr_state_t       state_q,
    output logic             ok_cur,
    output logic             ok_nxt
);
    localparam logic [VCC_W-1:0] RES_L = VCC_W'(RESUME_MV);
    localparam logic [VCC_W-1:0] PRO_L = VCC_W'(PROTECT_MV);
    localparam logic [VCC_W-1:0] SWI_L = VCC_W'(SWITCH_MV);
    localparam logic [VCC_W-1:0] SEA_L = VCC_W'(SEAL_MV);

    pwr_state_t state_d;

    always_comb begin
        state_d = next_pwr(state_q, vcc_mv, RES_L, PRO_L, SWI_L, SEA_L);
        ok_cur  = (state_q == PS_NORMAL);
        ok_nxt  = (state_d == PS_NORMAL);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_SEALED;
        else     state_q <= state_d;
    end

    // R2: once unsealed, never sealed again
    a_r2_seal_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_SEALED) |=> (state_q != PS_SEALED));
    // R4: low sample in normal forces exit from normal
    a_r4_protect_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_NORMAL && vcc_mv <= PRO_L) |=> (state_q != PS_NORMAL));
    // R3: no entry to normal without a sample above resume
    a_r3_resume_gate: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_NORMAL && vcc_mv <= RES_L) |=> (state_q != PS_NORMAL));
    // R5: backup held while supply remains below switch level
    a_r5_backup_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_BACKUP && vcc_mv < SWI_L) |=> (state_q == PS_BACKUP));
endmodule

// File: rtl/pfs_write_window.sv
module pfs_write_window
    import pfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ok_cur,
    input  logic              ok_nxt,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_en,
    output wr_beat_t          beat
);
    logic open_q;
    logic win_now;

    assign win_now = !ce_n && !we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            wr_en  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (!ok_cur || !ok_nxt) begin
                open_q <= 1'b0;
            end else if (win_now) begin
                open_q <= 1'b1;
            end else if (open_q) begin
                open_q <= 1'b0;
                wr_en  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) beat <= '0;
        else if (ok_cur && ok_nxt && win_now) beat <= '{addr: addr, data: wdata};
    end

    // R11: a commit only ever appears while the state is normal
    a_r11_commit_normal: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ok_cur);
    // R9: the write strobe lasts exactly one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
    import pfs_pkg::*;
#(
    parameter int RESUME_MV  = 4750,
    parameter int PROTECT_MV = 4500,
    parameter int SWITCH_MV  = 3000,
    parameter int SEAL_MV    = 4250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [12:0]       vcc_mv,
    input  logic              host_ce_n,
    input  logic              host_we_n,
    input  logic              host_oe_n,
    input  logic [14:0]       host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_rdata_oe,
    output logic [14:0]       arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              arr_wr_en,
    output logic              arr_rd_en,
    input  logic [7:0]        arr_rdata,
    output logic              bkup_sel,
    output logic              retain_ok,
    output logic [1:0]        pwr_state
);
    pwr_state_t st;
    logic       ok_cur, ok_nxt;
    wr_beat_t   beat;

    pfs_power_fsm #(
        .RESUME_MV(RESUME_MV), .PROTECT_MV(PROTECT_MV),
        .SWITCH_MV(SWITCH_MV), .SEAL_MV(SEAL_MV)
    ) u_fsm (
        .clk(clk), .rst(rst), .vcc_mv(vcc_mv),
        .state_q(st), .ok_cur(ok_cur), .ok_nxt(ok_nxt)
    );

    pfs_write_window u_win (
        .clk(clk), .rst(rst), .ok_cur(ok_cur), .ok_nxt(ok_nxt),
        .ce_n(host_ce_n), .we_n(host_we_n),
        .addr(host_addr), .wdata(host_wdata),
        .wr_en(arr_wr_en), .beat(beat)
    );

    always_comb begin
        arr_rd_en     = ok_cur && !host_ce_n && !host_oe_n && host_we_n;
        host_rdata_oe = arr_rd_en;
        host_rdata    = arr_rd_en ? arr_rdata : '0;
        arr_addr      = arr_wr_en ? beat.addr : host_addr;
        arr_wdata     = beat.data;
        bkup_sel      = (st == PS_BACKUP);
        retain_ok     = (st != PS_SEALED);
        pwr_state     = st;
    end

    // R8: an active write strobe never coexists with driven read data
    a_r8_we_kills_oe: assert property (@(posedge clk) disable iff (rst)
        !host_we_n |-> !host_rdata_oe);
    // R6: backup never selected while sealed
    a_r6_sealed_no_backup: assert property (@(posedge clk) disable iff (rst)
        bkup_sel |-> retain_ok);
    // R11: reads only in normal state
    a_r11_read_normal: assert property (@(posedge clk) disable iff (rst)
        host_rdata_oe |-> (pwr_state == 2'b01));
endmodule

// File: tb/pfs_supervisor_test.sv
module pfs_supervisor_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [12:0] vcc_mv = 13'd0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  host_rdata, arr_wdata, arr_rdata;
    logic [14:0] arr_addr;
    logic host_rdata_oe, arr_wr_en, arr_rd_en, bkup_sel, retain_ok;
    logic [1:0] pwr_state;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign arr_rdata = arr_addr[7:0] ^ 8'h5A;

    pfs_supervisor uut (
        .clk(clk), .rst(rst), .vcc_mv(vcc_mv),
        .host_ce_n(ce_n), .host_we_n(we_n), .host_oe_n(oe_n),
        .host_addr(addr), .host_wdata(wdata),
        .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_wr_en(arr_wr_en), .arr_rd_en(arr_rd_en), .arr_rdata(arr_rdata),
        .bkup_sel(bkup_sel), .retain_ok(retain_ok), .pwr_state(pwr_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic idle();
        ce_n = 1; we_n = 1; oe_n = 1;
    endtask

    task automatic do_reset();
        rst = 1; idle(); vcc_mv = 13'd0;
        tick(2);
        rst = 0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 state", pwr_state, 2'b00);
        chk("R1 bkup", bkup_sel, 0);
        chk("R1 retain", retain_ok, 0);
        chk("R1 wr", arr_wr_en, 0);
        chk("R1 rd", host_rdata_oe, 0);
    endtask

    task automatic t_seal();
        vcc_mv = 13'd2000; tick(2);
        chk("R2 sealed low", pwr_state, 2'b00);
        chk("R2 no backup when sealed", bkup_sel, 0);
        vcc_mv = 13'd4250; tick(2);
        chk("R2 sealed at level", pwr_state, 2'b00);
        vcc_mv = 13'd4400; tick();
        chk("R3 unseal to protect", pwr_state, 2'b10);
        chk("R6 retain", retain_ok, 1);
        vcc_mv = 13'd4700; tick(2);
        chk("R3 hold protect below resume", pwr_state, 2'b10);
        vcc_mv = 13'd4751; tick();
        chk("R3 resume", pwr_state, 2'b01);
    endtask

    task automatic t_read();
        ce_n = 0; oe_n = 0; we_n = 1; addr = 15'h1234; #1;
        chk("R7 oe", host_rdata_oe, 1);
        chk("R7 rd_en", arr_rd_en, 1);
        chk("R7 addr", arr_addr, 15'h1234);
        chk("R7 data", host_rdata, 8'h34 ^ 8'h5A);
        we_n = 0; #1;
        chk("R8 we disables", host_rdata_oe, 0);
        tick(); idle(); tick(2);
    endtask

    task automatic t_write();
        ce_n = 0; we_n = 0; addr = 15'h0ABC; wdata = 8'hC3;
        tick();
        wdata = 8'h3C; tick();
        chk("R9 no strobe while open", arr_wr_en, 0);
        addr = 15'h7FFF; we_n = 1; tick();
        chk("R9 strobe", arr_wr_en, 1);
        chk("R9 addr", arr_addr, 15'h0ABC);
        chk("R9 data", arr_wdata, 8'h3C);
        ce_n = 1; tick();
        chk("R9 one cycle", arr_wr_en, 0);
    endtask

    task automatic t_hyst();
        vcc_mv = 13'd4600; tick(2);
        chk("R4 stay normal in band", pwr_state, 2'b01);
        vcc_mv = 13'd4500; tick();
        chk("R4 protect", pwr_state, 2'b10);
        vcc_mv = 13'd4600; tick(2);
        chk("R4 band from below keeps protect", pwr_state, 2'b10);
    endtask

    task automatic t_ignore();
        int wr_seen = 0;
        ce_n = 0; oe_n = 0; we_n = 1; #1;
        chk("R11 no read when protected", host_rdata_oe, 0);
        chk("R11 no array read", arr_rd_en, 0);
        oe_n = 1; we_n = 0; tick(2); we_n = 1;
        for (int i = 0; i < 3; i++) begin tick(); wr_seen += arr_wr_en; end
        chk("R11 no write when protected", wr_seen, 0);
        idle(); tick();
    endtask

    task automatic t_abort();
        int wr_seen = 0;
        vcc_mv = 13'd5000; tick();
        chk("R3 back to normal", pwr_state, 2'b01);
        ce_n = 0; we_n = 0; addr = 15'h0042; wdata = 8'h99; tick(2);
        vcc_mv = 13'd4400; tick();
        chk("R4 protect mid window", pwr_state, 2'b10);
        vcc_mv = 13'd5000; tick();
        we_n = 1;
        for (int i = 0; i < 3; i++) begin tick(); wr_seen += arr_wr_en; end
        chk("R10 aborted window", wr_seen, 0);
        idle(); tick();
    endtask

    task automatic t_backup();
        vcc_mv = 13'd2500; tick();
        chk("R5 normal to backup", pwr_state, 2'b11);
        chk("R6 bkup_sel", bkup_sel, 1);
        vcc_mv = 13'd3000; tick(2);
        chk("R5 hold at level", pwr_state, 2'b11);
        vcc_mv = 13'd3500; tick();
        chk("R5 exit to protect", pwr_state, 2'b10);
        chk("R6 bkup off", bkup_sel, 0);
        vcc_mv = 13'd2000; tick();
        chk("R5 protect to backup", pwr_state, 2'b11);
        vcc_mv = 13'd4900; tick();
        chk("R3 backup to normal", pwr_state, 2'b01);
    endtask

    task automatic t_direct();
        do_reset();
        vcc_mv = 13'd5000; tick();
        chk("R3 sealed to normal", pwr_state, 2'b01);
        vcc_mv = 13'd1000; tick();
        chk("R2 never resealed", pwr_state, 2'b11);
        chk("R6 retain in backup", retain_ok, 1);
    endtask

    initial begin
        t_reset();
        t_seal();
        t_read();
        t_write();
        t_hyst();
        t_ignore();
        t_abort();
        t_backup();
        t_direct();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule